// File: doc/BRIEF.md
# Vertical-and-Crosswise Unsigned Multiplier

This block multiplies two unsigned 32-bit operands and returns the full 64-bit product. Each operand is split into an upper and a lower 16-bit half. Four 16x16 sub-multipliers form the four cross terms: low by low, low by high, high by low and high by high. A section assembler then adds the terms along the diagonals and passes the carries upward. The result is built as four explicit 16-bit sections.

Every 16x16 sub-multiplier is built the same way, one level down. The recursion doubles the width at each level (2, 4, 8, 16, 32) and ends at a 2x2 cell made of AND gates and half adders. No behavioural multiply is used in the datapath.

Operands enter on a valid/ready stream and the product leaves on another. With the optional output register enabled, the latency is one cycle. A product that is held under back-pressure does not change. The input side is ready whenever the output slot is empty or is being drained in the same cycle, so the block accepts one operand pair per cycle when the sink never stalls.

Top module: `ut_mul32`

## Requirements
- R1: For every accepted pair, the emitted product equals the unsigned product of the two 32-bit operands, as a 64-bit value.
- R2: Bits 15:0 of the product equal bits 15:0 of the product of the two low 16-bit halves.
- R3: If either operand is zero, the product is zero.
- R4: Two all-ones operands give the product 0xFFFFFFFE00000001.
- R5: A pair accepted at a rising edge (in_valid and in_ready both high) appears with out_valid high after that edge and before the next one.
- R6: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged at the next edge.
- R7: During reset and after it, out_valid is low until a pair has been accepted.
- R8: An edge at which in_ready is high and in_valid is low leaves out_valid low afterwards. Operand values presented without in_valid are never emitted.
- R9: With out_ready held high and in_valid held high, in_ready stays high and out_valid is high on every cycle after the first accepted pair, so one product leaves per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_a | input | 32 | First operand, unsigned |
| in_b | input | 32 | Second operand, unsigned |
| out_valid | output | 1 | Product present |
| out_ready | input | 1 | Sink takes the product this cycle |
| out_data | output | 64 | Unsigned product |

## Verification
Zero and all-ones operands, alone and mixed, test the extremes of the carry chains. All-ones by all-ones is the only case that sets every diagonal carry in the section assembler, while a single zero operand shows up any term that leaks from the wrong partial product. Random pairs with random valid and ready patterns test the cross-term alignment and the low-section rule. They also test the hold and drop rules, all under back-pressure. A long run with both valid and ready held high shows whether the block can take a new pair and emit a product on every cycle.

// File: rtl/ut_pkg.sv
package ut_pkg;
  // width of the leaf cell that ends the recursion
  localparam int unsigned UT_LEAF_W = 2;

  // true when w is a power of two no smaller than the leaf width
  function automatic bit ut_width_ok(input int unsigned w);
    int unsigned v;
    v = w;
    while (v > UT_LEAF_W && (v % 2) == 0) v = v / 2;
    return (v == UT_LEAF_W);
  endfunction
endpackage

// File: rtl/ut_leaf2.sv
module ut_leaf2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic t_a1b0, t_a0b1, t_a1b1;
  logic c_mid;

  always_comb begin
    // vertical terms
    p[0]   = a[0] & b[0];
    t_a1b1 = a[1] & b[1];
    // crosswise terms, half adder
    t_a1b0 = a[1] & b[0];
    t_a0b1 = a[0] & b[1];
    p[1]   = t_a1b0 ^ t_a0b1;
    c_mid  = t_a1b0 & t_a0b1;
    // second half adder
    p[2]   = t_a1b1 ^ c_mid;
    p[3]   = t_a1b1 & c_mid;
  end

  always_comb begin
    AST_LEAF_EXACT: assert ({2'b00, a} * {2'b00, b} == p); // R1
  end
endmodule

// File: rtl/ut_sec_asm.sv
module ut_sec_asm #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]   pll,
  input  logic [W-1:0]   plh,
  input  logic [W-1:0]   phl,
  input  logic [W-1:0]   phh,
  output logic [2*W-1:0] p
);
  localparam int unsigned H  = W / 2;
  localparam int unsigned MW = W + 2;

  logic [MW-1:0] mid;
  logic [W:0]    upper;

  always_comb begin
    // diagonal with the two cross terms and the carry-in from the low section
    mid   = MW'(pll[W-1:H]) + MW'(plh) + MW'(phl);
    // top diagonal takes the high term plus everything carried out of mid
    upper = (W+1)'(phh) + (W+1)'(mid[MW-1:H]);
    p     = {upper[W-1:0], mid[H-1:0], pll[H-1:0]};
  end

  always_comb begin
    AST_NO_CARRY_OUT: assert (upper[W] == 1'b0); // R1
  end
endmodule

// File: rtl/ut_vt_mul.sv
module ut_vt_mul #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  import ut_pkg::*;

  generate
    if (W == UT_LEAF_W) begin : g_leaf
      ut_leaf2 u_leaf (.a(a), .b(b), .p(p));
    end else begin : g_split
      localparam int unsigned H = W / 2;
      logic [W-1:0] t_ll, t_lh, t_hl, t_hh;

      ut_vt_mul #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(t_ll));
      ut_vt_mul #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(t_lh));
      ut_vt_mul #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(t_hl));
      ut_vt_mul #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(t_hh));

      ut_sec_asm #(.W(W)) u_asm (
        .pll(t_ll), .plh(t_lh), .phl(t_hl), .phh(t_hh), .p(p)
      );
    end
  endgenerate
endmodule

// File: rtl/ut_mul32.sv
module ut_mul32 #(
  parameter int unsigned DATA_W  = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_a,
  input  logic [DATA_W-1:0]   in_b,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*DATA_W-1:0] out_data
);
  import ut_pkg::*;

  localparam int unsigned H  = DATA_W / 2;
  localparam int unsigned PW = 2 * DATA_W;

  initial begin
    AST_WIDTH_POW2: assert (ut_width_ok(DATA_W)); // R1
  end

  // four half-width cross terms
  logic [DATA_W-1:0] pp_ll, pp_lh, pp_hl, pp_hh;
  logic [PW-1:0]     prod;

  ut_vt_mul #(.W(H)) u_ll (.a(in_a[H-1:0]),      .b(in_b[H-1:0]),      .p(pp_ll));
  ut_vt_mul #(.W(H)) u_lh (.a(in_a[H-1:0]),      .b(in_b[DATA_W-1:H]), .p(pp_lh));
  ut_vt_mul #(.W(H)) u_hl (.a(in_a[DATA_W-1:H]), .b(in_b[H-1:0]),      .p(pp_hl));
  ut_vt_mul #(.W(H)) u_hh (.a(in_a[DATA_W-1:H]), .b(in_b[DATA_W-1:H]), .p(pp_hh));

  // section assembly into four H-bit slices
  ut_sec_asm #(.W(DATA_W)) u_asm (
    .pll(pp_ll), .plh(pp_lh), .phl(pp_hl), .phh(pp_hh), .p(prod)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic          vld_q;
      logic [PW-1:0] dat_q;

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) dat_q <= prod;
        end
      end

      AST_LATENCY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R5
      AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_data == (PW'($past(in_a)) * PW'($past(in_b))))); // R1
      AST_LOW_SECTION: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_data[H-1:0] ==
          H'(DATA_W'($past(in_a[H-1:0])) * DATA_W'($past(in_b[H-1:0]))))); // R2
      AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
      AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> !out_valid); // R8
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = prod;
    end
  endgenerate
endmodule

// File: tb/ut_mul32_tb.sv
module ut_mul32_tb_top;
  localparam int CLK_P  = 10;
  localparam int WD_MAX = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_ready = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic [63:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ut_mul32 dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: queues of expected products, low sections and tags
  logic [63:0] q_prod[$];
  logic [15:0] q_low[$];
  string       q_tag[$];

  always @(posedge clk) begin
    logic rdy;
    if (!rst_n) begin
      q_prod.delete(); q_low.delete(); q_tag.delete();
    end else begin
      rdy = (q_prod.size() == 0) || out_ready;
      if (q_prod.size() != 0 && out_ready) begin
        void'(q_prod.pop_front()); void'(q_low.pop_front()); void'(q_tag.pop_front());
      end
      if (in_valid && rdy) begin
        q_prod.push_back(64'(in_a) * 64'(in_b));
        q_low.push_back(16'(32'(in_a[15:0]) * 32'(in_b[15:0])));
        if (in_a == 32'd0 || in_b == 32'd0)            q_tag.push_back("R3");
        else if (in_a == '1 && in_b == '1)              q_tag.push_back("R4");
        else                                            q_tag.push_back("R1");
      end
    end
  end

  // compare every cycle, a quarter period after the falling edge
  bit          prev_hold = 1'b0;
  logic [63:0] prev_data = '0;
  always @(negedge clk) begin
    bit ev;
    #(CLK_P/4);
    if (!rst_n) begin
      chk(out_valid == 1'b0, "R7", 64'(out_valid), 64'd0);
      prev_hold = 1'b0;
    end else begin
      ev = (q_prod.size() != 0);
      chk(out_valid == ev, ev ? "R5" : "R8", 64'(out_valid), 64'(ev));
      chk(in_ready == (!ev || out_ready), "R6", 64'(in_ready), 64'(!ev || out_ready));
      if (prev_hold)
        chk(out_valid && out_data == prev_data, "R6", out_data, prev_data);
      if (ev && out_valid) begin
        chk(out_data == q_prod[0], q_tag[0], out_data, q_prod[0]);
        chk(out_data[15:0] == q_low[0], "R2", 64'(out_data[15:0]), 64'(q_low[0]));
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
    end
  end

  task automatic drive(input logic v, input logic [31:0] a, input logic [31:0] b, input logic r);
    @(negedge clk);
    in_valid  = v;
    in_a      = a;
    in_b      = b;
    out_ready = r;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: idle right after reset release
    @(negedge clk); #(CLK_P/4);
    chk(out_valid == 1'b0, "R7", 64'(out_valid), 64'd0);
    // corners: zero and all-ones, R3 and R4
    drive(1'b1, 32'd0,        32'd0,        1'b1);
    drive(1'b1, 32'd0,        32'hFFFFFFFF, 1'b1);
    drive(1'b1, 32'hFFFFFFFF, 32'd0,        1'b1);
    drive(1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
    drive(1'b1, 32'd1,        32'hFFFFFFFF, 1'b1);
    drive(1'b1, 32'h0000FFFF, 32'hFFFF0000, 1'b1);
    drive(1'b0, 32'h12345678, 32'h9ABCDEF0, 1'b1);
    drive(1'b0, 32'hDEADBEEF, 32'hCAFEF00D, 1'b1);
    // R4 directed, with explicit value
    drive(1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
    drive(1'b0, 32'd0, 32'd0, 1'b1);
    #(CLK_P/4);
    chk(out_valid && out_data == 64'hFFFFFFFE00000001, "R4", out_data, 64'hFFFFFFFE00000001);
    // R8: invalid operands are dropped
    drive(1'b0, 32'h0BADF00D, 32'h77777777, 1'b1);
    #(CLK_P/4);
    chk(out_valid == 1'b0, "R8", 64'(out_valid), 64'd0);
    // R6: stall with a held product
    drive(1'b1, 32'h00010001, 32'h00020003, 1'b0);
    drive(1'b1, 32'h55555555, 32'hAAAAAAAA, 1'b0);
    drive(1'b1, 32'h55555555, 32'hAAAAAAAA, 1'b0);
    drive(1'b0, 32'd0, 32'd0, 1'b1);
    drive(1'b0, 32'd0, 32'd0, 1'b1);
    // R9: full throughput
    for (int i = 0; i < 40; i++) begin
      drive(1'b1, $urandom, $urandom, 1'b1);
      #(CLK_P/4);
      chk(in_ready == 1'b1, "R9", 64'(in_ready), 64'd1);
      if (i > 0) chk(out_valid == 1'b1, "R9", 64'(out_valid), 64'd1);
    end
    // random traffic with random valid and ready
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      case ($urandom % 8)
        0: ra = '0;
        1: rb = '1;
        2: ra = 32'(ra[15:0]);
        default: ;
      endcase
      drive(($urandom % 4) != 0, ra, rb, ($urandom % 3) != 0);
    end
    drive(1'b0, 32'd0, 32'd0, 1'b1);
    drive(1'b0, 32'd0, 32'd0, 1'b1);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WD_MAX) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule